// File: doc/BRIEF.md
# Exception Entry Arbiter

This unit sits beside a processor's fetch stage and decides, once per clock, whether an exception is to be taken and which one. Seven request lines arrive in parallel: reset, undefined instruction, software call, instruction-fetch abort, data-access abort, normal interrupt and fast interrupt. The unit masks the two interrupt lines with the mask bits of the current status word. It then picks the single most urgent request that is left.

For the chosen exception the unit produces a registered bundle one clock later. The bundle holds the take strobe, the handler vector address and the status word for the privileged mode being entered. It also holds a copy of the status word to be saved and the return-link value. The vector table sits either at address zero or at a high base, selected by an input pin. Handler code and the return from the handler belong to other logic.

The status word uses this layout: condition flags in bits 31:28, the interrupt mask I in bit 7, the fast-interrupt mask F in bit 6, the compact-instruction-state bit T in bit 5, and the mode field in bits 4:0.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `take_o` is 0 and `vec_o`, `status_o`, `saved_o` and `link_o` are all zero.
- R2: The outputs are registered. They reflect the inputs sampled at the previous rising clock edge. `take_o` is 1 exactly when at least one request survived masking at that edge.
- R3: When several requests survive masking, the winner is chosen in this order, highest first: reset, data abort, fast interrupt, interrupt, fetch abort, undefined instruction, software call.
- R4: The interrupt request is ignored while status bit 7 (I) is 1. The fast interrupt request is ignored while status bit 6 (F) is 1. A request that is masked in this way never becomes the winner and never causes `take_o` by itself.
- R5: The vector is the base plus the slot offset. The base is 0x00000000 when `hivec_i` is 0 and 0xFFFF0000 when it is 1. The slot offsets are: reset 0x00, undefined 0x04, software call 0x08, fetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C. No request uses offset 0x14.
- R6: `status_o[4:0]` carries the target mode. Reset and software call give supervisor (10011). Both aborts give abort (10111). Undefined gives undefined (11011). Interrupt gives 10010. Fast interrupt gives 10001.
- R7: In `status_o`, bit 5 (T) is 0 and bit 7 (I) is 1. Bit 6 (F) is 1 for reset and fast interrupt, and otherwise copies the sampled status bit 6. Bits 31:8 copy the sampled status word.
- R8: `saved_o` equals the status word sampled with the winning request.
- R9: `link_o` equals the sampled `pc_i` plus 4, wrapping modulo 2^32.
- R10: In any cycle where `take_o` is 0, `vec_o`, `status_o`, `saved_o` and `link_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rq_reset | input | 1 | Reset exception request |
| rq_undef | input | 1 | Undefined-instruction request |
| rq_swi | input | 1 | Software-call request |
| rq_pabt | input | 1 | Instruction-fetch abort request |
| rq_dabt | input | 1 | Data-access abort request |
| rq_irq | input | 1 | Interrupt request |
| rq_fiq | input | 1 | Fast interrupt request |
| status_i | input | 32 | Current status word |
| hivec_i | input | 1 | Selects the high vector base |
| pc_i | input | 32 | Address of the current instruction |
| take_o | output | 1 | Exception taken this cycle |
| vec_o | output | 32 | Handler vector address |
| status_o | output | 32 | Status word for the entered mode |
| saved_o | output | 32 | Status word to be saved |
| link_o | output | 32 | Return-link value |

## Verification
Most internal faults in this block surface at the ports one clock after the offending input pattern. A wrong priority rank or a broken mask shows in `vec_o` and `status_o[4:0]` in that cycle. A stale or mis-wired status path shows in `status_o` or `saved_o` in that same cycle. Driving all 128 request combinations under each mask setting and each vector base leaves no rank pair, mask case or base untested. A cycle-accurate model compares every output field on every clock, so a fault is reported within one cycle of the stimulus that exposes it.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Slot number of each exception: the vector offset is slot * 4.
    typedef enum logic [2:0] {
        EXC_RESET = 3'd0,
        EXC_UNDEF = 3'd1,
        EXC_SWI   = 3'd2,
        EXC_PABT  = 3'd3,
        EXC_DABT  = 3'd4,
        EXC_IRQ   = 3'd6,
        EXC_FIQ   = 3'd7
    } exc_kind_e;

    typedef enum logic [4:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } cpu_mode_e;

    typedef struct packed {
        logic [3:0]  flags;
        logic [19:0] mid;
        logic        imask;
        logic        fmask;
        logic        thumb;
        logic [4:0]  mode;
    } status_t;

    localparam int NUM_SRC   = 7;
    localparam int SLOT_BITS = 3;
    localparam int NUM_SLOT  = 1 << SLOT_BITS;

    // Rank 0 is the most urgent request.
    function automatic exc_kind_e prio_at(int rank);
        case (rank)
            0:       return EXC_RESET;
            1:       return EXC_DABT;
            2:       return EXC_FIQ;
            3:       return EXC_IRQ;
            4:       return EXC_PABT;
            5:       return EXC_UNDEF;
            default: return EXC_SWI;
        endcase
    endfunction

    function automatic cpu_mode_e mode_of(exc_kind_e k);
        case (k)
            EXC_RESET, EXC_SWI:  return MODE_SVC;
            EXC_PABT, EXC_DABT:  return MODE_ABT;
            EXC_UNDEF:           return MODE_UND;
            EXC_IRQ:             return MODE_IRQ;
            default:             return MODE_FIQ;
        endcase
    endfunction

    function automatic logic masks_fast(exc_kind_e k);
        return (k == EXC_RESET) || (k == EXC_FIQ);
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SLOT-1:0] req_slots,
    input  status_t             cur,
    output logic                valid,
    output exc_kind_e           kind
);
    logic [NUM_SLOT-1:0] elig;

    always_comb begin
        elig = req_slots;
        elig[EXC_IRQ]  = req_slots[EXC_IRQ] & ~cur.imask;
        elig[EXC_FIQ]  = req_slots[EXC_FIQ] & ~cur.fmask;
        elig[3'd5]     = 1'b0;
    end

    // Scan from the least urgent rank up, so the most urgent hit wins.
    always_comb begin
        valid = 1'b0;
        kind  = EXC_RESET;
        for (int r = NUM_SRC - 1; r >= 0; r--) begin
            if (elig[prio_at(r)]) begin
                valid = 1'b1;
                kind  = prio_at(r);
            end
        end
    end

    // R4
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && kind == EXC_IRQ) |-> !cur.imask);

    // R4
    fiq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && kind == EXC_FIQ) |-> !cur.fmask);

    // R3
    reset_first_chk: assert property (@(posedge clk) disable iff (rst)
        req_slots[EXC_RESET] |-> (valid && kind == EXC_RESET));

    // R3
    dabt_rank_chk: assert property (@(posedge clk) disable iff (rst)
        (req_slots[EXC_DABT] && !req_slots[EXC_RESET]) |-> (kind == EXC_DABT));

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_pkg::*;
#(
    parameter int             AW      = 32,
    parameter logic [AW-1:0]  HI_BASE = 32'hFFFF_0000
) (
    input  logic            hivec,
    input  exc_kind_e       kind,
    output logic [AW-1:0]   vec
);
    localparam int OFS_W = SLOT_BITS + 2;

    logic [AW-1:0] base;
    logic [AW-1:0] ofs;

    assign base = hivec ? HI_BASE : '0;

    generate
        if (AW > OFS_W) begin : g_wide
            assign ofs = {{(AW-OFS_W){1'b0}}, kind, 2'b00};
        end else begin : g_narrow
            assign ofs = AW'({kind, 2'b00});
        end
    endgenerate

    assign vec = base + ofs;

endmodule

// File: rtl/exc_status_gen.sv
module exc_status_gen
    import exc_pkg::*;
(
    input  status_t     cur,
    input  exc_kind_e   kind,
    output status_t     nxt
);
    always_comb begin
        nxt       = cur;
        nxt.mode  = mode_of(kind);
        nxt.thumb = 1'b0;
        nxt.imask = 1'b1;
        if (masks_fast(kind))
            nxt.fmask = 1'b1;
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int             AW        = 32,
    parameter logic [AW-1:0]  HI_BASE   = 32'hFFFF_0000,
    parameter int             LINK_STEP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rq_reset,
    input  logic            rq_undef,
    input  logic            rq_swi,
    input  logic            rq_pabt,
    input  logic            rq_dabt,
    input  logic            rq_irq,
    input  logic            rq_fiq,
    input  logic [31:0]     status_i,
    input  logic            hivec_i,
    input  logic [AW-1:0]   pc_i,
    output logic            take_o,
    output logic [AW-1:0]   vec_o,
    output logic [31:0]     status_o,
    output logic [31:0]     saved_o,
    output logic [AW-1:0]   link_o
);
    localparam logic [AW-1:0] LINK_INC = AW'(LINK_STEP);

    logic [NUM_SLOT-1:0] req_slots;
    status_t             cur;
    status_t             nxt;
    logic                win_valid;
    exc_kind_e           win_kind;
    logic [AW-1:0]       win_vec;

    assign cur = status_t'(status_i);

    always_comb begin
        req_slots            = '0;
        req_slots[EXC_RESET] = rq_reset;
        req_slots[EXC_UNDEF] = rq_undef;
        req_slots[EXC_SWI]   = rq_swi;
        req_slots[EXC_PABT]  = rq_pabt;
        req_slots[EXC_DABT]  = rq_dabt;
        req_slots[EXC_IRQ]   = rq_irq;
        req_slots[EXC_FIQ]   = rq_fiq;
    end

    exc_arbiter arb_i (
        .clk       (clk),
        .rst       (rst),
        .req_slots (req_slots),
        .cur       (cur),
        .valid     (win_valid),
        .kind      (win_kind)
    );

    exc_vector_gen #(.AW(AW), .HI_BASE(HI_BASE)) vgen_i (
        .hivec (hivec_i),
        .kind  (win_kind),
        .vec   (win_vec)
    );

    exc_status_gen sgen_i (
        .cur  (cur),
        .kind (win_kind),
        .nxt  (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst || !win_valid) begin
            take_o   <= 1'b0;
            vec_o    <= '0;
            status_o <= '0;
            saved_o  <= '0;
            link_o   <= '0;
        end else begin
            take_o   <= 1'b1;
            vec_o    <= win_vec;
            status_o <= nxt;
            saved_o  <= status_i;
            link_o   <= pc_i + LINK_INC;
        end
    end

    // Set once a clock edge has been seen with reset low, so $past is meaningful.
    logic past_ok;
    always_ff @(posedge clk) begin
        past_ok <= !rst;
    end

    logic any_live;
    assign any_live = rq_reset | rq_undef | rq_swi | rq_pabt | rq_dabt
                    | (rq_irq & ~status_i[7]) | (rq_fiq & ~status_i[6]);

    // R2
    take_match_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        take_o == $past(any_live));

    // R8
    saved_copy_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        take_o |-> saved_o == $past(status_i));

    // R9
    link_step_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        take_o |-> link_o == $past(pc_i) + LINK_INC);

    // R7
    entry_bits_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        take_o |-> (!status_o[5] && status_o[7] && status_o[31:8] == $past(status_i[31:8])));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (vec_o == '0 && status_o == '0 && saved_o == '0 && link_o == '0));

    // R5
    reset_vec_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (take_o && $past(rq_reset)) |-> (vec_o[4:0] == 5'd0 && status_o[4:0] == MODE_SVC));

endmodule

// File: tb/exc_entry_unit_tb_top.sv
`timescale 1ns/1ps
module exc_entry_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rq_reset = 0, rq_undef = 0, rq_swi = 0, rq_pabt = 0;
    logic        rq_dabt = 0, rq_irq = 0, rq_fiq = 0;
    logic [31:0] status_i = '0;
    logic        hivec_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic        take_o;
    logic [31:0] vec_o, status_o, saved_o, link_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic        e_take;
    logic [31:0] e_vec, e_stat, e_saved, e_link;

    always #2 clk = ~clk;

    exc_entry_unit dut_i (
        .clk(clk), .rst(rst),
        .rq_reset(rq_reset), .rq_undef(rq_undef), .rq_swi(rq_swi),
        .rq_pabt(rq_pabt), .rq_dabt(rq_dabt), .rq_irq(rq_irq), .rq_fiq(rq_fiq),
        .status_i(status_i), .hivec_i(hivec_i), .pc_i(pc_i),
        .take_o(take_o), .vec_o(vec_o), .status_o(status_o),
        .saved_o(saved_o), .link_o(link_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural model: the request word is indexed by slot number
    // (0 reset, 1 undef, 2 swi, 3 pabt, 4 dabt, 6 irq, 7 fiq).
    task automatic model(input logic [7:0] rq, input logic [31:0] st,
                         input logic hv, input logic [31:0] pc);
        int order[$] = '{0, 4, 7, 6, 3, 1, 2};
        int win = -1;
        logic [7:0] live = rq;
        if (st[7]) live[6] = 1'b0;
        if (st[6]) live[7] = 1'b0;
        while (order.size() > 0 && win < 0) begin
            int s = order.pop_front();
            if (live[s]) win = s;
        end
        e_take = 0; e_vec = 0; e_stat = 0; e_saved = 0; e_link = 0;
        if (win >= 0) begin
            logic [4:0] md;
            case (win)
                0, 2:    md = 5'b10011;
                3, 4:    md = 5'b10111;
                1:       md = 5'b11011;
                6:       md = 5'b10010;
                default: md = 5'b10001;
            endcase
            e_take  = 1;
            e_vec   = (hv ? 32'hFFFF0000 : 32'h0) + 32'(win * 4);
            e_stat  = {st[31:8], 1'b1, (st[6] | win == 0 | win == 7), 1'b0, md};
            e_saved = st;
            e_link  = pc + 32'd4;
        end
    endtask

    task automatic drive(input logic [7:0] rq, input logic [31:0] st,
                         input logic hv, input logic [31:0] pc);
        {rq_fiq, rq_irq, rq_dabt, rq_pabt, rq_swi, rq_undef, rq_reset} =
            {rq[7], rq[6], rq[4], rq[3], rq[2], rq[1], rq[0]};
        status_i = st; hivec_i = hv; pc_i = pc;
        model(rq, st, hv, pc);
    endtask

    task automatic compare_all();
        chk(take_o == e_take, "R2", "take", {31'd0, take_o}, {31'd0, e_take});
        chk(vec_o == e_vec, e_take ? "R3" : "R10", "vector/priority", vec_o, e_vec);
        chk(status_o[4:0] == e_stat[4:0], "R6", "mode", {27'd0, status_o[4:0]}, {27'd0, e_stat[4:0]});
        chk(status_o[31:5] == e_stat[31:5], "R7", "status bits", status_o, e_stat);
        chk(saved_o == e_saved, "R8", "saved", saved_o, e_saved);
        chk(link_o == e_link, "R9", "link", link_o, e_link);
    endtask

    task automatic step(input logic [7:0] rq, input logic [31:0] st,
                        input logic hv, input logic [31:0] pc);
        drive(rq, st, hv, pc);
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [7:0] spread(input int c);
        return {c[6], c[5], 1'b0, c[4], c[3], c[2], c[1], c[0]};
    endfunction

    initial begin
        drive(8'hDF, 32'h0000_0010, 1'b1, 32'h100);
        repeat (3) @(negedge clk);
        // R1: outputs stay clear while reset is held, even with requests active
        chk(take_o == 0 && vec_o == 0 && status_o == 0 && saved_o == 0 && link_o == 0,
            "R1", "reset state", {31'd0, take_o}, 32'd0);
        rst = 1'b0;
        drive(8'h00, 32'h0000_0010, 1'b0, 32'h0);
        @(negedge clk);
        chk(take_o == 0, "R1", "first cycle after reset", {31'd0, take_o}, 32'd0);

        // R3 R4 R5: every request combination under each mask pair and base
        for (int hv = 0; hv < 2; hv++)
            for (int m = 0; m < 4; m++)
                for (int c = 0; c < 128; c++) begin
                    logic [31:0] st;
                    st = {c[3:0], 20'(c * 7919 + m), m[1], m[0], c[0] ^ hv[0],
                          (c[1] ? 5'b11111 : 5'b10000)};
                    step(spread(c), st, hv[0], 32'(c * 32'h0101_0104 + m * 16));
                end

        // R4: interrupt alone under its mask gives nothing
        step(8'h40, 32'h0000_0090, 1'b0, 32'h40);
        chk(take_o == 0, "R4", "masked interrupt", {31'd0, take_o}, 32'd0);
        step(8'h80, 32'h0000_0050, 1'b0, 32'h40);
        chk(take_o == 0, "R4", "masked fast interrupt", {31'd0, take_o}, 32'd0);
        // R9: link wraps
        step(8'h02, 32'hF000_0030, 1'b0, 32'hFFFF_FFFC);
        chk(link_o == 32'h0, "R9", "link wrap", link_o, 32'h0);
        // R5: high base for fast interrupt
        step(8'h80, 32'h0000_0010, 1'b1, 32'h0);
        chk(vec_o == 32'hFFFF_001C, "R5", "high fiq vector", vec_o, 32'hFFFF_001C);
        // R10: idle after a taken cycle
        step(8'h00, 32'h1234_5610, 1'b1, 32'h80);
        chk(vec_o == 0 && link_o == 0, "R10", "idle clear", vec_o, 32'h0);

        // R1: reset in mid-run clears the registered bundle
        drive(8'h01, 32'h0000_0010, 1'b0, 32'h0);
        rst = 1'b1;
        @(negedge clk);
        chk(take_o == 0 && status_o == 0, "R1", "reset mid-run", status_o, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule